// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Row Refresh

This block sits between a simple synchronous host port and a bank of one-bit-wide dynamic memory devices that take their address in two halves over a shared bus. Eight devices run side by side so that each location holds a byte. The bank can be built from two-device modules. The two devices in a module share the address, data and write-enable lines and differ only in their select strobes. The controller therefore drives one row strobe and one column strobe per device half.

A host request is accepted with a valid/ready handshake. The controller splits the host address into a column field, a row field and a half-select field. It lowers the row strobe of the chosen half with the row field on the bus. After a short programmable hold it moves the bus to the column field and then lowers the column strobe. Writes drive the byte and write enable before the column strobe falls. Reads capture the byte a set number of cycles later and return it with a one-cycle valid pulse.

A timer raises a refresh request at a fixed interval. The interval is derived from the retention window so that every row is visited within that window. A refresh lowers all row strobes together with the refresh row counter on the bus and never touches a column strobe. A pending refresh takes precedence over the host: the host waits with ready low until the refresh cycle has been issued.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, all row and column strobes are high, write enable is high, the data drive enable is low, rsp_valid is low and req_ready is high.
- R2: The host address splits as column = req_addr[ROW_W-1:0], row = req_addr[2*ROW_W-1:ROW_W], and half = the top bit(s). The row field is on the bus when the row strobe falls and stays there for T_RAH cycles. The column field is on the bus when the column strobe falls.
- R3: A pending refresh holds req_ready low. A host request that arrives while a refresh is pending is accepted only after the refresh cycle has been issued.
- R4: During a host access only the selected half's row and column strobes go low, and at most one column strobe is low at any time.
- R5: A refresh cycle lowers every row strobe at once and keeps all column strobes high.
- R6: The refresh row counter starts at 0 after reset, advances by one after each refresh cycle, and wraps from 2^ROW_W-1 to 0.
- R7: Between two low periods of the row strobes, all row strobes stay high for at least T_RP cycles.
- R8: A read returns the byte stored at its address. rsp_valid is a single-cycle pulse arriving T_RCD+T_RDLAT+1 clock edges after the accepting edge.
- R9: For a write, write enable is low and the data drive enable is high on the cycle before the column strobe falls and on the cycle it falls. The driven byte is what the selected device half stores.
- R10: Refresh requests recur every (RETAIN_CYC >> ROW_W) - (T_RCD+T_CAS+T_RP+1) cycles. As a result, consecutive refresh cycles start no more than RETAIN_CYC >> ROW_W cycles apart, even under continuous host traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address {half, row, column} |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read byte |
| dram_addr | output | ROW_W | Multiplexed row/column address bus |
| dram_ras_n | output | N_HALF | Row strobes, one per device half, active low |
| dram_cas_n | output | N_HALF | Column strobes, one per device half, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to the devices |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | DATA_W | Read data from the devices |

## Verification
The hardest case to reach is a refresh tick that lands while a host request is already waiting or an access is in flight. This case matters for both refresh priority and the worst-case refresh spacing. The bench uses a short retention window and issues host accesses back to back through a full write sweep and a full read sweep of a small bank. The refresh timer therefore collides with host traffic many times at many different phases. A port-level device model records each refresh row, the gap between refresh starts, and whether a host request was stalled across a refresh.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACT,
      ST_CAS,
      ST_PRE,
      ST_REF
   } seq_state_t;

   typedef enum logic [1:0] {
      BUS_ROW,
      BUS_COL,
      BUS_REF
   } bus_sel_t;

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int ROW_W      = 7,
   parameter int REF_PERIOD = 1500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_done,
   output logic             ref_pend,
   output logic [ROW_W-1:0] ref_row
);

   localparam int TW = $clog2(REF_PERIOD + 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(REF_PERIOD - 1);

   logic [TW-1:0] tick_cnt;
   logic          tick;

   assign tick = (tick_cnt == TICK_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (tick) begin
         tick_cnt <= '0;
      end else begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_pend <= 1'b0;
      end else if (tick) begin
         ref_pend <= 1'b1;
      end else if (ref_done) begin
         ref_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_row <= '0;
      end else if (ref_done) begin
         ref_row <= ref_row + 1'b1;
      end
   end

   // R6: row counter wraps to zero after the last row
   a_r6_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_done && (ref_row == '1)) |=> (ref_row == '0));

   // R10: a timer tick always leaves a request pending
   a_r10_tick_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ref_pend);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
   import dram_seq_pkg::*;
#(
   parameter int ROW_W  = 7,
   parameter int N_HALF = 2,
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [ROW_W-1:0]  ref_row,
   input  bus_sel_t          bus_sel,
   output logic [ROW_W-1:0]  bus_addr,
   output logic [N_HALF-1:0] half_oh
);

   logic [ROW_W-1:0] col_f;
   logic [ROW_W-1:0] row_f;

   assign col_f = addr_q[ROW_W-1:0];
   assign row_f = addr_q[2*ROW_W-1:ROW_W];

   always_comb begin
      unique case (bus_sel)
         BUS_ROW: bus_addr = row_f;
         BUS_COL: bus_addr = col_f;
         default: bus_addr = ref_row;
      endcase
   end

   generate
      if (N_HALF > 1) begin : g_multi
         localparam int SEL_W = $clog2(N_HALF);
         logic [SEL_W-1:0] half_f;
         assign half_f = addr_q[ADDR_W-1 -: SEL_W];
         for (genvar h = 0; h < N_HALF; h++) begin : g_dec
            assign half_oh[h] = (half_f == SEL_W'(h));
         end
      end else begin : g_single
         assign half_oh = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int T_RAH    = 2,
   parameter int T_RCD    = 3,
   parameter int T_CAS    = 3,
   parameter int T_RDLAT  = 1,
   parameter int T_RP     = 2,
   parameter int T_REFRAS = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     ref_pend,
   input  logic     we_q,
   output logic     req_ready,
   output logic     accept,
   output logic     ras_act,
   output logic     cas_act,
   output logic     ref_act,
   output logic     ref_done,
   output logic     rd_capture,
   output bus_sel_t bus_sel
);

   localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
   localparam int M2   = (T_RP > T_REFRAS) ? T_RP : T_REFRAS;
   localparam int MAXT = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXT + 1);

   localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] L_CAS = CW'(T_CAS - 1);
   localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] L_REF = CW'(T_REFRAS - 1);
   localparam logic [CW-1:0] L_RAH = CW'(T_RAH);
   localparam logic [CW-1:0] L_RDL = CW'(T_RDLAT);

   seq_state_t    state;
   logic [CW-1:0] cnt;

   assign req_ready  = (state == ST_IDLE) && !ref_pend;
   assign accept     = req_ready && req_valid;
   assign ras_act    = (state == ST_ACT) || (state == ST_CAS);
   assign cas_act    = (state == ST_CAS);
   assign ref_act    = (state == ST_REF);
   assign ref_done   = (state == ST_REF) && (cnt == L_REF);
   assign rd_capture = (state == ST_CAS) && (cnt == L_RDL) && !we_q;

   always_comb begin
      if (state == ST_REF) begin
         bus_sel = BUS_REF;
      end else if ((state == ST_ACT) && (cnt < L_RAH)) begin
         bus_sel = BUS_ROW;
      end else begin
         bus_sel = BUS_COL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (ref_pend) begin
                  state <= ST_REF;
               end else if (req_valid) begin
                  state <= ST_ACT;
               end
            end
            ST_ACT: begin
               if (cnt == L_RCD) begin
                  state <= ST_CAS;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CAS: begin
               if (cnt == L_CAS) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PRE: begin
               if (cnt == L_RP) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == L_REF) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   // R3: no host acceptance while a refresh is waiting
   a_r3_ref_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> !req_ready);

   // R8: read capture happens at most once per access
   a_r8_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture |=> !rd_capture);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_seq_pkg::*;
#(
   parameter int ROW_W      = 7,
   parameter int N_HALF     = 2,
   parameter int DATA_W     = 8,
   parameter int T_RAH      = 2,
   parameter int T_RCD      = 3,
   parameter int T_CAS      = 3,
   parameter int T_RDLAT    = 1,
   parameter int T_RP       = 2,
   parameter int T_REFRAS   = 3,
   parameter int RETAIN_CYC = 200000,
   localparam int SEL_W      = (N_HALF > 1) ? $clog2(N_HALF) : 0,
   localparam int ADDR_W     = 2 * ROW_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ROW_W-1:0]  dram_addr,
   output logic [N_HALF-1:0] dram_ras_n,
   output logic [N_HALF-1:0] dram_cas_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);

   localparam int ACCESS_CYC = T_RCD + T_CAS + T_RP + 1;
   localparam int REF_PERIOD = (RETAIN_CYC >> ROW_W) - ACCESS_CYC;
   localparam int HW         = $clog2(T_RP + 2);

   generate
      if (T_RAH < 1 || T_RAH >= T_RCD) begin : g_bad_rah
         $error("T_RAH must lie in 1..T_RCD-1");
      end
      if (T_RDLAT >= T_CAS) begin : g_bad_rdlat
         $error("T_RDLAT must be below T_CAS");
      end
      if ((N_HALF & (N_HALF - 1)) != 0) begin : g_bad_half
         $error("N_HALF must be a power of two");
      end
      if (REF_PERIOD <= T_REFRAS + T_RP + 1) begin : g_bad_ref
         $error("retention window too short for the timing set");
      end
      if (T_RP < 1 || T_CAS < 1 || T_REFRAS < 1) begin : g_bad_t
         $error("strobe timings must be at least one cycle");
      end
   endgenerate

   logic              accept;
   logic              ras_act;
   logic              cas_act;
   logic              ref_act;
   logic              ref_done;
   logic              rd_capture;
   logic              ref_pend;
   logic [ROW_W-1:0]  ref_row;
   logic [N_HALF-1:0] half_oh;
   bus_sel_t          bus_sel;

   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         we_q    <= req_we;
         wdata_q <= req_wdata;
      end
   end

   dram_seq_fsm #(
      .T_RAH    (T_RAH),
      .T_RCD    (T_RCD),
      .T_CAS    (T_CAS),
      .T_RDLAT  (T_RDLAT),
      .T_RP     (T_RP),
      .T_REFRAS (T_REFRAS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .ref_pend   (ref_pend),
      .we_q       (we_q),
      .req_ready  (req_ready),
      .accept     (accept),
      .ras_act    (ras_act),
      .cas_act    (cas_act),
      .ref_act    (ref_act),
      .ref_done   (ref_done),
      .rd_capture (rd_capture),
      .bus_sel    (bus_sel)
   );

   dram_refresh_sched #(
      .ROW_W      (ROW_W),
      .REF_PERIOD (REF_PERIOD)
   ) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_done (ref_done),
      .ref_pend (ref_pend),
      .ref_row  (ref_row)
   );

   dram_addr_mux #(
      .ROW_W  (ROW_W),
      .N_HALF (N_HALF),
      .ADDR_W (ADDR_W)
   ) u_mux (
      .addr_q   (addr_q),
      .ref_row  (ref_row),
      .bus_sel  (bus_sel),
      .bus_addr (dram_addr),
      .half_oh  (half_oh)
   );

   logic [N_HALF-1:0] ras_low;
   logic [N_HALF-1:0] cas_low;

   always_comb begin
      if (ref_act) begin
         ras_low = '1;
      end else if (ras_act) begin
         ras_low = half_oh;
      end else begin
         ras_low = '0;
      end
      cas_low = cas_act ? half_oh : '0;
   end

   assign dram_ras_n  = ~ras_low;
   assign dram_cas_n  = ~cas_low;
   assign dram_we_n   = ~(we_q & ras_act);
   assign dram_dq_oe  = we_q & ras_act;
   assign dram_dq_out = wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_capture;
         if (rd_capture) begin
            rsp_rdata <= dram_dq_in;
         end
      end
   end

   // strobe history used by the timing assertions below
   logic [N_HALF-1:0] ras_prev;
   logic [N_HALF-1:0] cas_prev;
   logic [HW-1:0]     hi_cnt;
   logic              ras_fall;
   logic              cas_fall;

   assign ras_fall = |(~ras_prev & ras_low);
   assign cas_fall = |(~cas_prev & cas_low);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_prev <= '0;
         cas_prev <= '0;
         hi_cnt   <= HW'(T_RP);
      end else begin
         ras_prev <= ras_low;
         cas_prev <= cas_low;
         if (ras_low != '0) begin
            hi_cnt <= '0;
         end else if (hi_cnt < HW'(T_RP)) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   // R4: never more than one column strobe low
   a_r4_cas_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dram_cas_n));

   // R2: a column strobe only falls inside its own half's row strobe
   a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
      ((~dram_cas_n) & dram_ras_n) == '0);

   // R7: row strobes rest high for the precharge time
   a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fall |-> (hi_cnt >= HW'(T_RP)));

   // R9: write enable already low the cycle before a write column strobe
   a_r9_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_fall && !dram_we_n) |-> $past(!dram_we_n && dram_dq_oe));

   generate
      if (N_HALF > 1) begin : g_ref_chk
         // R5: all-half row strobe never carries a column strobe
         a_r5_ref_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
            (dram_ras_n == '0) |-> (dram_cas_n == '1));
      end
   endgenerate

endmodule

// File: tb/tb_dram_seq_ctrl.sv
module tb_dram_seq_ctrl;

   localparam int ROW_W      = 4;
   localparam int N_HALF     = 2;
   localparam int DATA_W     = 8;
   localparam int T_RAH      = 2;
   localparam int T_RCD      = 3;
   localparam int T_CAS      = 3;
   localparam int T_RDLAT    = 1;
   localparam int T_RP       = 2;
   localparam int T_REFRAS   = 3;
   localparam int RETAIN_CYC = 800;
   localparam int ADDR_W     = 2 * ROW_W + 1;
   localparam int NLOC       = 1 << ADDR_W;
   localparam int NROW       = 1 << ROW_W;
   localparam int GAP_MAX    = RETAIN_CYC >> ROW_W;
   localparam int RD_LAT     = T_RCD + T_RDLAT + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_we = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic [ROW_W-1:0]  dram_addr;
   logic [N_HALF-1:0] dram_ras_n;
   logic [N_HALF-1:0] dram_cas_n;
   logic              dram_we_n;
   logic [DATA_W-1:0] dram_dq_out;
   logic              dram_dq_oe;
   logic [DATA_W-1:0] dram_dq_in;

   always #5 clk = ~clk;

   dram_seq_ctrl #(
      .ROW_W      (ROW_W),
      .N_HALF     (N_HALF),
      .DATA_W     (DATA_W),
      .T_RAH      (T_RAH),
      .T_RCD      (T_RCD),
      .T_CAS      (T_CAS),
      .T_RDLAT    (T_RDLAT),
      .T_RP       (T_RP),
      .T_REFRAS   (T_REFRAS),
      .RETAIN_CYC (RETAIN_CYC)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_we      (req_we),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .dram_addr   (dram_addr),
      .dram_ras_n  (dram_ras_n),
      .dram_cas_n  (dram_cas_n),
      .dram_we_n   (dram_we_n),
      .dram_dq_out (dram_dq_out),
      .dram_dq_oe  (dram_dq_oe),
      .dram_dq_in  (dram_dq_in)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // device bank model driven only from the pins
   logic [DATA_W-1:0] bmem [NLOC];
   int  m_half = 0;
   int  m_row  = 0;
   int  m_col  = 0;
   int  acc_addr = 0;
   bit  host_waiting = 1'b0;
   bit  mon_en = 1'b0;

   int  err_r2 = 0;
   int  err_r4 = 0;
   int  err_r5 = 0;
   int  err_r6 = 0;
   int  err_r7 = 0;
   int  err_r9 = 0;
   int  ref_cnt = 0;
   int  ref_stall = 0;
   int  exp_ref_row = 0;
   int  gap = 0;
   int  max_gap = 0;
   bit  seen_ref = 1'b0;
   int  hi_cyc = 100;
   int  acc_cyc = 0;
   bit  in_acc = 1'b0;
   logic [N_HALF-1:0] ras_p = '1;
   logic [N_HALF-1:0] cas_p = '1;
   logic              we_p  = 1'b1;
   logic              oe_p  = 1'b0;

   assign dram_dq_in = bmem[m_half * (NROW * NROW) + m_row * NROW + m_col];

   always @(negedge clk) begin
      if (mon_en) begin
         gap++;
         acc_cyc++;
         if ((ras_p == '1) && (dram_ras_n == '0)) begin
            // R5 / R6 / R10: refresh start
            ref_cnt++;
            if (int'(dram_addr) != exp_ref_row) err_r6++;
            exp_ref_row = (exp_ref_row + 1) % NROW;
            if (dram_cas_n != '1) err_r5++;
            if (hi_cyc < T_RP) err_r7++;
            if (seen_ref && gap > max_gap) max_gap = gap;
            seen_ref = 1'b1;
            gap = 0;
            if (host_waiting) ref_stall++;
            in_acc = 1'b0;
         end else if ((ras_p == '1) && (dram_ras_n != '1)) begin
            // host access start
            if (hi_cyc < T_RP) err_r7++;
            if ($countones(~dram_ras_n) != 1) err_r4++;
            m_half = dram_ras_n[0] ? 1 : 0;
            m_row  = int'(dram_addr);
            if (m_half != (acc_addr >> (2 * ROW_W))) err_r2++;
            if (m_row != ((acc_addr >> ROW_W) % NROW)) err_r2++;
            in_acc  = 1'b1;
            acc_cyc = 0;
         end
         if (in_acc && dram_ras_n != '1 && acc_cyc > 0 && acc_cyc < T_RAH &&
             int'(dram_addr) != m_row) err_r2++;
         if (dram_ras_n != '0 && dram_cas_n != '1 && (dram_cas_n != dram_ras_n)) err_r4++;
         if ((cas_p == '1) && (dram_cas_n != '1)) begin
            m_col = int'(dram_addr);
            if (m_col != (acc_addr % NROW)) err_r2++;
            if (!dram_we_n) begin
               if (we_p || !oe_p || !dram_dq_oe) err_r9++;
               bmem[m_half * (NROW * NROW) + m_row * NROW + m_col] = dram_dq_out;
            end
         end
         if (dram_ras_n == '1) begin
            if (hi_cyc < 1000) hi_cyc++;
         end else begin
            hi_cyc = 0;
         end
         ras_p = dram_ras_n;
         cas_p = dram_cas_n;
         we_p  = dram_we_n;
         oe_p  = dram_dq_oe;
      end
   end

   function automatic logic [7:0] pat(input int a, input int k);
      pat = 8'((a * 37 + 11 + k * 91) ^ (a >> 3));
   endfunction

   task automatic host_op(input bit we, input int a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
      @(posedge clk);
      #2;
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = ADDR_W'(a);
      req_wdata = d;
      host_waiting = 1'b1;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk);
      acc_addr     = a;
      host_waiting = 1'b0;
      #1;
      req_valid = 1'b0;
      lat = 0;
      rd  = '0;
      if (!we) begin
         forever begin
            @(posedge clk);
            lat++;
            #1;
            if (rsp_valid) begin
               rd = rsp_rdata;
               break;
            end
            if (lat > 50) break;
         end
         @(posedge clk);
         #1;
         // R8: pulse lasts one cycle
         chk(!rsp_valid, "R8 pulse width", int'(rsp_valid), 0);
      end
   endtask

   initial begin
      logic [7:0] rd;
      int lat;
      int rd_err;
      int lat_err;
      for (int i = 0; i < NLOC; i++) bmem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs idle while reset is held
      chk(dram_ras_n == '1, "R1 ras in reset", int'(dram_ras_n), 3);
      chk(dram_cas_n == '1, "R1 cas in reset", int'(dram_cas_n), 3);
      chk(dram_we_n && !dram_dq_oe, "R1 we/oe in reset", int'({dram_we_n, dram_dq_oe}), 2);
      chk(!rsp_valid, "R1 rsp_valid in reset", int'(rsp_valid), 0);
      @(posedge clk);
      #1;
      rst_n  = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
      chk(dram_ras_n == '1, "R1 ras after reset", int'(dram_ras_n), 3);

      // R9: full write sweep across both halves
      for (int a = 0; a < NLOC; a++) host_op(1'b1, a, pat(a, 0), rd, lat);

      // R8: full read sweep, data and latency
      rd_err = 0;
      lat_err = 0;
      for (int a = 0; a < NLOC; a++) begin
         host_op(1'b0, a, 8'h00, rd, lat);
         if (rd != pat(a, 0)) begin
            rd_err++;
            if (rd_err < 5) chk(1'b0, "R8 read data", int'(rd), int'(pat(a, 0)));
         end
         if (lat != RD_LAT) lat_err++;
      end
      chk(rd_err == 0, "R8 R9 read sweep mismatches", rd_err, 0);
      chk(lat_err == 0, "R8 read latency errors", lat_err, 0);
      host_op(1'b0, 5, 8'h00, rd, lat);
      chk(lat == RD_LAT, "R8 latency sample", lat, RD_LAT);

      // R4: same row/column in both halves must stay apart
      host_op(1'b1, 17, 8'h00, rd, lat);
      host_op(1'b1, 17 + NROW * NROW, 8'hFF, rd, lat);
      host_op(1'b0, 17, 8'h00, rd, lat);
      chk(rd == 8'h00, "R4 lower half kept", int'(rd), 0);
      host_op(1'b0, 17 + NROW * NROW, 8'h00, rd, lat);
      chk(rd == 8'hFF, "R4 upper half kept", int'(rd), 255);

      // R2: corner addresses, interleaved write/read
      for (int k = 0; k < 4; k++) begin
         automatic int a = (k == 0) ? 0 : (k == 1) ? NROW - 1 :
                           (k == 2) ? (NROW - 1) * NROW : NLOC - 1;
         host_op(1'b1, a, pat(a, 3), rd, lat);
         host_op(1'b0, a, 8'h00, rd, lat);
         chk(rd == pat(a, 3), "R2 corner address", int'(rd), int'(pat(a, 3)));
      end

      repeat (10) @(negedge clk);
      chk(err_r2 == 0, "R2 bus field errors", err_r2, 0);
      chk(err_r4 == 0, "R4 strobe isolation errors", err_r4, 0);
      chk(err_r5 == 0, "R5 refresh with column strobe", err_r5, 0);
      chk(err_r6 == 0, "R6 refresh row order errors", err_r6, 0);
      chk(ref_cnt >= 2 * NROW, "R6 refresh wrapped counter", ref_cnt, 2 * NROW);
      chk(err_r7 == 0, "R7 precharge violations", err_r7, 0);
      chk(err_r9 == 0, "R9 write setup errors", err_r9, 0);
      chk(ref_stall > 0, "R3 refresh ahead of waiting host", ref_stall, 1);
      chk(max_gap <= GAP_MAX, "R10 refresh spacing", max_gap, GAP_MAX);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule